// File: doc/BRIEF.md
# DRAM Rank Clock-Enable Power-State Tracker

This block follows the power state of one DRAM rank from the device's side of the interface. On every clock it looks at the registered clock-enable level, a decoded strobe that marks a self-refresh entry command, a vector of per-bank open-row flags and a flag that is high while a read or write burst is in flight. From these inputs it decides whether the rank is active, in precharge power-down, in active power-down or in self-refresh. It then drives enables for the input-buffer groups and for the output drivers.

When clock enable drops, the kind of low-power state depends on the banks. If any row is open, the rank enters active power-down. If all banks are idle, it enters precharge power-down, or self-refresh when the entry strobe arrives in the same cycle. Power-down keeps the clock, termination-control and clock-enable receivers alive. Self-refresh keeps only the clock-enable receiver. A high clock enable starts a wake sequence of a fixed, parameterised number of cycles. During that sequence the input buffers are already back on and the output drivers are still off. A clock-enable drop while a burst is running is illegal: it is flagged and has no effect on the state.

All pins are plain level control and status signals. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `cke_power_tracker`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves pwr_mode=0 (active), wake_busy=0, cke_drop_err=0, and all four buffer enables and drv_en at 1.
- R2: In the active state, with no wake in progress, a sampled cke_smp=0 with burst_busy=0, all bank_open bits 0 and sref_entry=0 moves pwr_mode to 1 (precharge power-down) at that edge.
- R3: Under the same conditions but with sref_entry=1, pwr_mode moves to 3 (self-refresh).
- R4: In the active state, cke_smp=0 with burst_busy=0 and any bank_open bit set moves pwr_mode to 2 (active power-down), whatever the value of sref_entry.
- R5: In pwr_mode 1 or 2: buf_en_ca=0, buf_en_ck=1, buf_en_odt=1, buf_en_cke=1 and drv_en=0.
- R6: In pwr_mode 3: buf_en_cke=1, and buf_en_ca, buf_en_ck, buf_en_odt and drv_en are all 0.
- R7: In the active state, cke_smp=0 while burst_busy=1 leaves pwr_mode at 0 and sets cke_drop_err to 1 for the following cycle only, unless the violation repeats.
- R8: In any low-power mode, a sampled cke_smp=1 starts a wake lasting EXIT_CYC cycles. During the wake, pwr_mode=0, wake_busy=1, all four buffer enables are 1 and drv_en=0. After the wake the rank is active with wake_busy=0 and drv_en=1.
- R9: While in a low-power mode with cke_smp=0, sref_entry and bank_open have no effect on pwr_mode. During a wake, cke_smp has no effect.
- R10: In the active state, cke_smp=1 keeps the rank active with all enables at 1 and cke_drop_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke_smp | input | 1 | Registered clock-enable level |
| sref_entry | input | 1 | Decoded self-refresh entry command strobe |
| bank_open | input | NBANK | Per-bank open-row flags |
| burst_busy | input | 1 | High while a read or write burst is in flight |
| pwr_mode | output | 2 | 0 active, 1 precharge power-down, 2 active power-down, 3 self-refresh |
| wake_busy | output | 1 | High during the wake sequence |
| buf_en_ca | output | 1 | Command/address input buffer enable |
| buf_en_ck | output | 1 | Clock receiver enable |
| buf_en_odt | output | 1 | Termination-control input enable |
| buf_en_cke | output | 1 | Clock-enable input buffer enable |
| drv_en | output | 1 | Output driver enable |
| cke_drop_err | output | 1 | Illegal clock-enable drop during a burst |

## Verification
The main sequence drops clock enable under three bank and command combinations: all banks idle without the strobe, all banks idle with the strobe, and one open row with and without the strobe. These cases separate the three low-power flavours and show that an open row takes precedence over self-refresh. Each flavour is then left with a high clock enable, and the wake length is counted against EXIT_CYC. A low clock enable during the wake and a strobe during power-down are applied to show that neither has any effect. A drop during a burst is applied both alone and followed by a legal level, so the error pulse is told apart from a sticky flag. A reset in the middle of self-refresh is also tried.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;
  typedef enum logic [2:0] {
    PS_ACT  = 3'd0,
    PS_PPD  = 3'd1,
    PS_APD  = 3'd2,
    PS_SREF = 3'd3,
    PS_WAKE = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/cke_pwr_fsm.sv
module cke_pwr_fsm
  import cke_pwr_pkg::*;
#(
  parameter int EXIT_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic       sre,
  input  logic       any_open,
  input  logic       busy,
  output pwr_state_e state_o
);
  localparam int CNT_W = (EXIT_CYC < 2) ? 1 : $clog2(EXIT_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EXIT_CYC - 1);

  pwr_state_e state, nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    unique case (state)
      PS_ACT: begin
        if (!cke && !busy) begin
          if (any_open)  nxt = PS_APD;
          else if (sre)  nxt = PS_SREF;
          else           nxt = PS_PPD;
        end
      end
      PS_PPD, PS_APD, PS_SREF: begin
        if (cke) begin
          nxt     = PS_WAKE;
          cnt_nxt = CNT_LOAD;
        end
      end
      PS_WAKE: begin
        if (cnt == '0) nxt = PS_ACT;
        else           cnt_nxt = cnt - 1'b1;
      end
      default: nxt = PS_ACT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PS_ACT;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
    end
  end

  assign state_o = state;

  // R2: idle drop without strobe enters precharge power-down
  assert_ppd_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (state == PS_ACT && !cke && !busy && !any_open && !sre) |=> (state == PS_PPD));

  // R3: idle drop with strobe enters self-refresh
  assert_sref_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (state == PS_ACT && !cke && !busy && !any_open && sre) |=> (state == PS_SREF));

  // R4: open row gives active power-down
  assert_apd_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (state == PS_ACT && !cke && !busy && any_open) |=> (state == PS_APD));

  // R8: wake starts with full count loaded
  assert_wake_load_R8: assert property (@(posedge clk) disable iff (rst)
    ((state == PS_PPD || state == PS_APD || state == PS_SREF) && cke)
      |=> (state == PS_WAKE && cnt == CNT_LOAD));

  // R9: low-power mode held while clock enable stays low
  assert_lp_hold_R9: assert property (@(posedge clk) disable iff (rst)
    ((state == PS_PPD || state == PS_APD || state == PS_SREF) && !cke) |=> $stable(state));
endmodule

// File: rtl/cke_buf_decode.sv
module cke_buf_decode
  import cke_pwr_pkg::*;
(
  input  pwr_state_e state_i,
  output logic [1:0] mode_o,
  output logic       wake_o,
  output logic       en_ca,
  output logic       en_ck,
  output logic       en_odt,
  output logic       en_cke,
  output logic       en_drv
);
  always_comb begin
    mode_o = 2'd0;
    wake_o = 1'b0;
    en_ca  = 1'b1;
    en_ck  = 1'b1;
    en_odt = 1'b1;
    en_cke = 1'b1;
    en_drv = 1'b1;
    unique case (state_i)
      PS_ACT: ;
      PS_PPD, PS_APD: begin
        mode_o = (state_i == PS_PPD) ? 2'd1 : 2'd2;
        en_ca  = 1'b0;
        en_drv = 1'b0;
      end
      PS_SREF: begin
        mode_o = 2'd3;
        en_ca  = 1'b0;
        en_ck  = 1'b0;
        en_odt = 1'b0;
        en_drv = 1'b0;
      end
      PS_WAKE: begin
        wake_o = 1'b1;
        en_drv = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cke_drop_guard.sv
module cke_drop_guard (
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic busy,
  input  logic in_active,
  output logic err_o
);
  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= in_active && !cke && busy;
  end

  // R7: flag only follows an active-state drop during a burst
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(!cke && busy && in_active));
endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
  import cke_pwr_pkg::*;
#(
  parameter int NBANK    = 16,
  parameter int EXIT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke_smp,
  input  logic             sref_entry,
  input  logic [NBANK-1:0] bank_open,
  input  logic             burst_busy,
  output logic [1:0]       pwr_mode,
  output logic             wake_busy,
  output logic             buf_en_ca,
  output logic             buf_en_ck,
  output logic             buf_en_odt,
  output logic             buf_en_cke,
  output logic             drv_en,
  output logic             cke_drop_err
);
  pwr_state_e st;
  logic any_open;

  assign any_open = |bank_open;

  cke_pwr_fsm #(.EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .cke     (cke_smp),
    .sre     (sref_entry),
    .any_open(any_open),
    .busy    (burst_busy),
    .state_o (st)
  );

  cke_buf_decode u_dec (
    .state_i(st),
    .mode_o (pwr_mode),
    .wake_o (wake_busy),
    .en_ca  (buf_en_ca),
    .en_ck  (buf_en_ck),
    .en_odt (buf_en_odt),
    .en_cke (buf_en_cke),
    .en_drv (drv_en)
  );

  cke_drop_guard u_guard (
    .clk      (clk),
    .rst      (rst),
    .cke      (cke_smp),
    .busy     (burst_busy),
    .in_active(st == PS_ACT),
    .err_o    (cke_drop_err)
  );

  // R1: state after reset
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (pwr_mode == 2'd0 && !wake_busy && !cke_drop_err && drv_en &&
                    buf_en_ca && buf_en_ck && buf_en_odt && buf_en_cke));

  // R5: power-down buffer set
  assert_pd_bufs_R5: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode == 2'd1 || pwr_mode == 2'd2) |->
      (!buf_en_ca && buf_en_ck && buf_en_odt && buf_en_cke && !drv_en));

  // R6: self-refresh keeps only the clock-enable receiver
  assert_sref_bufs_R6: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode == 2'd3) |->
      (!buf_en_ca && !buf_en_ck && !buf_en_odt && buf_en_cke && !drv_en));

  // R7: a drop during a burst never leaves the active state
  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode == 2'd0 && !wake_busy && !cke_smp && burst_busy) |=> (pwr_mode == 2'd0));
endmodule

// File: tb/cke_power_tracker_tb.sv
module cke_power_tracker_tb;
  localparam int NBANK    = 16;
  localparam int EXIT_CYC = 4;

  logic clk = 1'b0;
  logic rst;
  logic cke_smp, sref_entry, burst_busy;
  logic [NBANK-1:0] bank_open;
  logic [1:0] pwr_mode;
  logic wake_busy, buf_en_ca, buf_en_ck, buf_en_odt, buf_en_cke, drv_en, cke_drop_err;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  cke_power_tracker #(.NBANK(NBANK), .EXIT_CYC(EXIT_CYC)) u_dut (
    .clk(clk), .rst(rst), .cke_smp(cke_smp), .sref_entry(sref_entry),
    .bank_open(bank_open), .burst_busy(burst_busy), .pwr_mode(pwr_mode),
    .wake_busy(wake_busy), .buf_en_ca(buf_en_ca), .buf_en_ck(buf_en_ck),
    .buf_en_odt(buf_en_odt), .buf_en_cke(buf_en_cke), .drv_en(drv_en),
    .cke_drop_err(cke_drop_err)
  );

  // {cke, sre, banks[15:0], busy, mode[1:0], wake, err}
  localparam int NV = 30;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0},  // 0 stay active
    {1'b0, 1'b0, 16'h0000, 1'b0, 2'd1, 1'b0, 1'b0},  // 1 ppd
    {1'b0, 1'b0, 16'h0000, 1'b0, 2'd1, 1'b0, 1'b0},  // 2
    {1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 1'b0},  // 3 wake
    {1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0},  // 7 active
    {1'b0, 1'b0, 16'h0010, 1'b0, 2'd2, 1'b0, 1'b0},  // 8 apd
    {1'b0, 1'b1, 16'h0000, 1'b0, 2'd2, 1'b0, 1'b0},  // 9 strobe and banks ignored
    {1'b1, 1'b0, 16'h0010, 1'b0, 2'd0, 1'b1, 1'b0},  // 10 wake
    {1'b1, 1'b0, 16'h0010, 1'b0, 2'd0, 1'b1, 1'b0},
    {1'b0, 1'b0, 16'h0010, 1'b0, 2'd0, 1'b1, 1'b0},  // 12 low cke ignored
    {1'b1, 1'b0, 16'h0010, 1'b0, 2'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0},  // 14 active
    {1'b0, 1'b1, 16'h0000, 1'b0, 2'd3, 1'b0, 1'b0},  // 15 sref
    {1'b0, 1'b0, 16'h0000, 1'b0, 2'd3, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 1'b0},  // 17 wake
    {1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0},  // 21 active
    {1'b0, 1'b0, 16'h0001, 1'b1, 2'd0, 1'b0, 1'b1},  // 22 illegal drop
    {1'b1, 1'b0, 16'h0001, 1'b1, 2'd0, 1'b0, 1'b0},  // 23 pulse ends
    {1'b0, 1'b1, 16'h8000, 1'b0, 2'd2, 1'b0, 1'b0},  // 24 open row beats strobe
    {1'b1, 1'b0, 16'h8000, 1'b0, 2'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h8000, 1'b0, 2'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h8000, 1'b0, 2'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h8000, 1'b0, 2'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0}   // 29 active
  };

  // {ca, ck, odt, cke, drv} from R5, R6, R8, R10
  function automatic logic [4:0] exp_en(input logic [1:0] m, input logic w);
    if (w)            return 5'b11110;
    else if (m == 2'd0) return 5'b11111;
    else if (m == 2'd3) return 5'b00010;
    else              return 5'b01110;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic s, input logic [NBANK-1:0] b, input logic bz);
    cke_smp = c; sref_entry = s; bank_open = b; burst_busy = bz;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string mode_req(input int i, input logic [1:0] m, input logic w);
    if (i == 9 || i == 12) return "R9";
    if (w)            return "R8";
    if (m == 2'd1)    return "R2";
    if (m == 2'd3)    return "R3";
    if (m == 2'd2)    return "R4";
    return "R10";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cke_smp = 1'b1; sref_entry = 1'b0; bank_open = '0; burst_busy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "mode", pwr_mode, 0);
    chk("R1", "wake", wake_busy, 0);
    chk("R1", "err", cke_drop_err, 0);
    chk("R1", "enables", {buf_en_ca, buf_en_ck, buf_en_odt, buf_en_cke, drv_en}, 5'b11111);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      string rq;
      v = VEC[i];
      cyc(v[22], v[21], v[20:5], v[4]);
      rq = mode_req(i, v[3:2], v[1]);
      chk(rq, "mode", pwr_mode, v[3:2]);
      chk(rq, "wake", wake_busy, v[1]);
      chk((i == 22 || i == 23) ? "R7" : rq, "err", cke_drop_err, v[0]);
      chk(v[1] ? "R8" : (v[3:2] == 2'd3) ? "R6" : (v[3:2] == 2'd0) ? "R10" : "R5",
          "enables", {buf_en_ca, buf_en_ck, buf_en_odt, buf_en_cke, drv_en},
          exp_en(v[3:2], v[1]));
    end

    // R7 repeated violation keeps flag, state stays active
    cyc(1'b0, 1'b0, 16'h0002, 1'b1);
    cyc(1'b0, 1'b0, 16'h0002, 1'b1);
    chk("R7", "err repeat", cke_drop_err, 1);
    chk("R7", "mode repeat", pwr_mode, 0);
    cyc(1'b1, 1'b0, 16'h0000, 1'b0);
    chk("R7", "err clear", cke_drop_err, 0);

    // R1 reset in the middle of self-refresh
    cyc(1'b0, 1'b1, 16'h0000, 1'b0);
    chk("R3", "mode before reset", pwr_mode, 3);
    rst = 1'b1;
    cyc(1'b0, 1'b0, 16'h0000, 1'b0);
    rst = 1'b0;
    chk("R1", "mode after reset", pwr_mode, 0);
    chk("R1", "enables after reset",
        {buf_en_ca, buf_en_ck, buf_en_odt, buf_en_cke, drv_en}, 5'b11111);
    chk("R1", "wake after reset", wake_busy, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule